// File: doc/BRIEF.md
# Doorbell write-match test counter

A bus-attached test peripheral that counts writes to a doorbell address. It has two byte-wide windows on one request/response port: a memory window and a port-I/O window. A request's `req_space_i` bit picks the window. A write of a small value to offset 0 of either window selects one of three tests for that window and arms it. While a test is armed, every write that lands on that test's doorbell address and meets the test's qualification rules increments a counter.

Software reads the result back one byte at a time through a header image of the armed test. The image holds:
- the test index;
- the access width;
- the doorbell address;
- the expected data byte;
- the counter;
- an ASCII test name.

Multi-byte fields are little-endian. A read that falls outside the image returns zero, and so does any read while no test is armed.

Each test has one of three flavours:
- **plain:** counts any write at the doorbell.
- **any:** also counts any write at the doorbell.
- **match:** counts a write only if it is one byte wide and carries the expected byte.

Top module: `dbt_doorbell_counter`

## Requirements
- R1: A write to offset 0 of either window always disarms the active test first. If the written value is 0, 1 or 2, it arms test index = window*3 + value, where the memory window is 0 and the port window is 1. A value of 3 or more leaves the block disarmed. A select write is never also counted as a doorbell hit.
- R2: Arming a test clears its counter to zero.
- R3: While no test is armed, writes to nonzero offsets have no effect and every read returns 0.
- R4: The doorbell address of test i is MEM_BASE + i for i in 0..2 and IO_BASE + i for i in 3..5 (defaults 2048 and 128). A write counts only at that address, whichever window carries it. An access at or beyond its window's span (MEM_SPAN 4096, IO_SPAN 256) is ignored.
- R5: The match tests (index 2 and 5) count a write only when `req_size_i` is 1 and the data is MATCH_BYTE (0xFA). The other tests count any data and any size.
- R6: The header image has this byte layout:

  | Byte | Content |
  |------|---------|
  | 0 | test index |
  | 1 | width, always 1 |
  | 2–3 | zero |
  | 4–7 | doorbell address, little-endian |
  | 8 | expected byte: 0xFA for match tests, MISS_BYTE 0xCE otherwise |
  | 9–11 | zero |
  | 12–15 | counter, little-endian, zero-extended from CNT_W bits |

- R7: Bytes 16 onward hold the test name followed by a zero byte. The names are mem-plain, mem-any, mem-match, io-plain, io-any and io-match, for indices 0 to 5.
- R8: A read returns 0 when address + `req_size_i` is greater than or equal to the image length, which is 17 + name length.
- R9: Reset disarms the block, and `req_ready_o` is low while reset is held.
- R10: Out of reset `req_ready_o` is high. Every accepted request gets `rsp_valid_o` exactly one cycle later, and `rsp_rdata_o` is 0 for writes.
- R11: The counter wraps modulo 2^CNT_W. A counted write is visible to a read issued on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_space_i | input | 1 | Window select: 0 memory, 1 port I/O |
| req_addr_i | input | ADDR_W | Byte offset in the window |
| req_size_i | input | 3 | Original access size in bytes |
| req_wdata_i | input | 8 | Write data byte |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_rdata_o | output | 8 | Read data byte |

## Verification
The bench builds the block with default addresses, spans and data bytes, but with CNT_W = 6. This puts counter wrap-around within 65 doorbell writes, and the R11 check exercises it. The default address parameters keep both windows at their full spans. This allows the bench to reach the following cases:
- a port-window write at an address that only the memory window decodes, which must be ignored;
- a memory-window write that lands on a port test's doorbell, which must count.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  localparam int unsigned TESTS_PER_WIN = 3;
  localparam int unsigned NUM_TESTS     = 2 * TESTS_PER_WIN;
  localparam int unsigned HDR_BYTES     = 16;
  localparam int unsigned NAME_MAX      = 9;
  localparam int unsigned IDX_W         = $clog2(NUM_TESTS);

  typedef enum logic {WIN_MEM = 1'b0, WIN_IO = 1'b1} win_e;

  localparam logic [8*NAME_MAX-1:0] NM_MEM_PLAIN = 72'("mem-plain");
  localparam logic [8*NAME_MAX-1:0] NM_MEM_ANY   = 72'("mem-any");
  localparam logic [8*NAME_MAX-1:0] NM_MEM_MATCH = 72'("mem-match");
  localparam logic [8*NAME_MAX-1:0] NM_IO_PLAIN  = 72'("io-plain");
  localparam logic [8*NAME_MAX-1:0] NM_IO_ANY    = 72'("io-any");
  localparam logic [8*NAME_MAX-1:0] NM_IO_MATCH  = 72'("io-match");

  function automatic logic is_match(input logic [IDX_W-1:0] idx);
    return (idx == IDX_W'(2)) || (idx == IDX_W'(5));
  endfunction

  function automatic int unsigned name_len(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(0), IDX_W'(2): return 9;
      IDX_W'(1):            return 7;
      IDX_W'(3), IDX_W'(5): return 8;
      default:              return 6;
    endcase
  endfunction

  function automatic logic [7:0] name_byte(input logic [IDX_W-1:0] idx, input int unsigned pos);
    logic [8*NAME_MAX-1:0] s;
    int unsigned n;
    case (idx)
      IDX_W'(0): s = NM_MEM_PLAIN;
      IDX_W'(1): s = NM_MEM_ANY;
      IDX_W'(2): s = NM_MEM_MATCH;
      IDX_W'(3): s = NM_IO_PLAIN;
      IDX_W'(4): s = NM_IO_ANY;
      default:   s = NM_IO_MATCH;
    endcase
    n = name_len(idx);
    if (pos >= n) return 8'h00;
    return s[8*(n-1-pos) +: 8];
  endfunction
endpackage

// File: rtl/dbt_decode.sv
module dbt_decode
  import dbt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned MEM_SPAN   = 4096,
  parameter int unsigned IO_SPAN    = 256,
  parameter logic [7:0]  MATCH_BYTE = 8'hFA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              write_i,
  input  logic              space_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic [7:0]        wdata_i,
  input  logic              armed_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [31:0]       bell_off_i,
  output logic              sel_o,
  output logic              sel_ok_o,
  output logic [IDX_W-1:0]  sel_idx_o,
  output logic              bell_o
);
  logic in_span, wr, qual;

  always_comb begin
    if (win_e'(space_i) == WIN_IO) in_span = {1'b0, addr_i} < (ADDR_W+1)'(IO_SPAN);
    else                           in_span = {1'b0, addr_i} < (ADDR_W+1)'(MEM_SPAN);
    wr        = fire_i & write_i & in_span;
    sel_o     = wr & (addr_i == '0);
    sel_ok_o  = wdata_i < 8'(TESTS_PER_WIN);
    sel_idx_o = IDX_W'(wdata_i[1:0]) + (space_i ? IDX_W'(TESTS_PER_WIN) : IDX_W'(0));
    qual      = !is_match(idx_i) || ((size_i == 3'd1) && (wdata_i == MATCH_BYTE));
    bell_o    = wr & !sel_o & armed_i & (32'(addr_i) == bell_off_i) & qual;
  end

  assert_sel_priority_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> !bell_o);
  assert_bell_armed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bell_o |-> armed_i);
  assert_match_qual_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bell_o && is_match(idx_i) |-> size_i == 3'd1 && wdata_i == MATCH_BYTE);
endmodule

// File: rtl/dbt_state.sv
module dbt_state
  import dbt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             sel_ok_i,
  input  logic [IDX_W-1:0] sel_idx_i,
  input  logic             bell_i,
  output logic             armed_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      idx_o   <= '0;
      cnt_o   <= '0;
    end else if (sel_i) begin
      armed_o <= sel_ok_i;
      if (sel_ok_i) begin
        idx_o <= sel_idx_i;
        cnt_o <= '0;
      end
    end else if (bell_i) begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  assert_reject_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && !sel_ok_i |=> !armed_o);
  assert_arm_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && sel_ok_i |=> armed_o && idx_o == $past(sel_idx_i));
  assert_idx_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |-> idx_o < IDX_W'(NUM_TESTS));
  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && sel_ok_i |=> cnt_o == '0);
  assert_wrap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i && bell_i |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i && !bell_i |=> $stable(cnt_o) && $stable(armed_o) && $stable(idx_o));
endmodule

// File: rtl/dbt_image.sv
module dbt_image
  import dbt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned CNT_W      = 32,
  parameter logic [7:0]  MATCH_BYTE = 8'hFA,
  parameter logic [7:0]  MISS_BYTE  = 8'hCE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        size_i,
  input  logic              armed_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [31:0]       bell_off_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              rsp_valid_o,
  output logic [7:0]        rsp_rdata_o
);
  localparam int unsigned LEN_W = ADDR_W + 2;

  logic [31:0]      cnt32;
  logic [LEN_W-1:0] rec_len, end_pos;
  logic [7:0]       img_byte, rdata_d;
  logic             oor;

  assign cnt32 = 32'(cnt_i);

  always_comb begin
    rec_len = LEN_W'(HDR_BYTES + 1 + name_len(idx_i));
    end_pos = LEN_W'(addr_i) + LEN_W'(size_i);
    oor     = end_pos >= rec_len;
    img_byte = 8'h00;
    if ({1'b0, addr_i} >= (ADDR_W+1)'(HDR_BYTES)) begin
      img_byte = name_byte(idx_i, int'(addr_i) - int'(HDR_BYTES));
    end else begin
      case (addr_i[3:0])
        4'd0:  img_byte = 8'(idx_i);
        4'd1:  img_byte = 8'd1;
        4'd4:  img_byte = bell_off_i[7:0];
        4'd5:  img_byte = bell_off_i[15:8];
        4'd6:  img_byte = bell_off_i[23:16];
        4'd7:  img_byte = bell_off_i[31:24];
        4'd8:  img_byte = is_match(idx_i) ? MATCH_BYTE : MISS_BYTE;
        4'd12: img_byte = cnt32[7:0];
        4'd13: img_byte = cnt32[15:8];
        4'd14: img_byte = cnt32[23:16];
        4'd15: img_byte = cnt32[31:24];
        default: img_byte = 8'h00;
      endcase
    end
    rdata_d = (fire_i && !write_i && armed_i && !oor) ? img_byte : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= 8'h00;
    end else begin
      rsp_valid_o <= fire_i;
      rsp_rdata_o <= rdata_d;
    end
  end

  assert_rsp_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> rsp_valid_o);
  assert_no_spurious_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> !rsp_valid_o);
  assert_write_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && write_i |=> rsp_rdata_o == 8'h00);
  assert_idle_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !armed_i |=> rsp_rdata_o == 8'h00);
  assert_oor_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && oor |=> rsp_rdata_o == 8'h00);
endmodule

// File: rtl/dbt_doorbell_counter.sv
module dbt_doorbell_counter
  import dbt_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned MEM_SPAN   = 4096,
  parameter int unsigned IO_SPAN    = 256,
  parameter int unsigned MEM_BASE   = 2048,
  parameter int unsigned IO_BASE    = 128,
  parameter int unsigned CNT_W      = 32,
  parameter logic [7:0]  MATCH_BYTE = 8'hFA,
  parameter logic [7:0]  MISS_BYTE  = 8'hCE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_space_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_size_i,
  input  logic [7:0]        req_wdata_i,
  output logic              rsp_valid_o,
  output logic [7:0]        rsp_rdata_o
);
  logic             fire, sel, sel_ok, bell, armed;
  logic [IDX_W-1:0] sel_idx, idx;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      bell_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_ready_o <= 1'b0;
    else         req_ready_o <= 1'b1;
  end

  assign fire     = req_valid_i & req_ready_o;
  assign bell_off = (idx >= IDX_W'(TESTS_PER_WIN)) ? 32'(IO_BASE) + 32'(idx)
                                                   : 32'(MEM_BASE) + 32'(idx);

  dbt_decode #(
    .ADDR_W(ADDR_W), .MEM_SPAN(MEM_SPAN), .IO_SPAN(IO_SPAN), .MATCH_BYTE(MATCH_BYTE)
  ) i_decode (
    .clk_i, .rst_ni,
    .fire_i(fire), .write_i(req_write_i), .space_i(req_space_i),
    .addr_i(req_addr_i), .size_i(req_size_i), .wdata_i(req_wdata_i),
    .armed_i(armed), .idx_i(idx), .bell_off_i(bell_off),
    .sel_o(sel), .sel_ok_o(sel_ok), .sel_idx_o(sel_idx), .bell_o(bell)
  );

  dbt_state #(.CNT_W(CNT_W)) i_state (
    .clk_i, .rst_ni,
    .sel_i(sel), .sel_ok_i(sel_ok), .sel_idx_i(sel_idx), .bell_i(bell),
    .armed_o(armed), .idx_o(idx), .cnt_o(cnt)
  );

  dbt_image #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MATCH_BYTE(MATCH_BYTE), .MISS_BYTE(MISS_BYTE)
  ) i_image (
    .clk_i, .rst_ni,
    .fire_i(fire), .write_i(req_write_i), .addr_i(req_addr_i), .size_i(req_size_i),
    .armed_i(armed), .idx_i(idx), .bell_off_i(bell_off), .cnt_i(cnt),
    .rsp_valid_o, .rsp_rdata_o
  );

  assert_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> req_ready_o);
endmodule

// File: tb/test_dbt_doorbell_counter.sv
`timescale 1ns/1ps
module test_dbt_doorbell_counter;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_space = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [2:0] req_size = 3'd1;
  logic [7:0] req_wdata = 8'h00;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbt_doorbell_counter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_dbt_doorbell_counter (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_space_i(req_space), .req_addr_i(req_addr), .req_size_i(req_size),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata)
  );

  function automatic string exp_name(input int idx);
    case (idx)
      0: return "mem-plain"; 1: return "mem-any"; 2: return "mem-match";
      3: return "io-plain";  4: return "io-any";  default: return "io-match";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit sp, input int addr, input int sz,
                        input int data, output logic [7:0] rd, output logic vld);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_space = sp;
    req_addr = ADDR_W'(addr); req_size = 3'(sz); req_wdata = 8'(data);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; vld = rsp_valid;
  endtask

  task automatic wr(input bit sp, input int addr, input int sz, input int data);
    logic [7:0] rd; logic v;
    access(1'b1, sp, addr, sz, data, rd, v);
  endtask

  task automatic rd_chk(input string req, input bit sp, input int addr, input int sz, input int exp);
    logic [7:0] rd; logic v;
    access(1'b0, sp, addr, sz, 0, rd, v);
    chk(req, int'(rd), exp);
  endtask

  task automatic t_reset;
    logic [7:0] rd; logic v;
    chk("R9 ready low in reset", int'(req_ready), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready high", int'(req_ready), 1);
    chk("R10 no rsp when idle", int'(rsp_valid), 0);
    wr(1'b0, 2048, 1, 8'h55);
    access(1'b0, 1'b0, 0, 1, 0, rd, v);
    chk("R3 idle read zero", int'(rd), 0);
    chk("R10 rsp valid", int'(v), 1);
  endtask

  task automatic t_header_mem0;
    wr(1'b0, 0, 1, 0);
    rd_chk("R6 idx", 1'b0, 0, 1, 0);
    rd_chk("R6 width", 1'b0, 1, 1, 1);
    rd_chk("R6 pad", 1'b0, 2, 1, 0);
    rd_chk("R6 off lo", 1'b0, 4, 1, 8'h00);
    rd_chk("R6 off hi", 1'b0, 5, 1, 8'h08);
    rd_chk("R6 miss byte", 1'b0, 8, 1, 8'hCE);
    rd_chk("R2 cnt zero", 1'b0, 12, 1, 0);
  endtask

  task automatic t_doorbell;
    logic [7:0] rd; logic v;
    repeat (3) wr(1'b0, 2048, 4, 8'h33);
    wr(1'b0, 2049, 1, 8'h33);
    rd_chk("R4 count only at doorbell", 1'b0, 12, 1, 3);
    access(1'b1, 1'b0, 2048, 1, 0, rd, v);
    chk("R10 write rsp valid", int'(v), 1);
    chk("R10 write rdata zero", int'(rd), 0);
    rd_chk("R11 next-cycle visibility", 1'b0, 12, 1, 4);
    wr(1'b0, 0, 1, 0);
    rd_chk("R2 rearm clears", 1'b0, 12, 1, 0);
  endtask

  task automatic t_match;
    wr(1'b0, 0, 1, 2);
    rd_chk("R6 match idx", 1'b0, 0, 1, 2);
    rd_chk("R6 match byte", 1'b0, 8, 1, 8'hFA);
    rd_chk("R6 match off", 1'b0, 4, 1, 8'h02);
    wr(1'b0, 2050, 1, 8'h11);
    wr(1'b0, 2050, 2, 8'hFA);
    rd_chk("R5 wrong data or size ignored", 1'b0, 12, 1, 0);
    wr(1'b0, 2050, 1, 8'hFA);
    rd_chk("R5 match counted", 1'b0, 12, 1, 1);
    wr(1'b1, 0, 1, 1);
    wr(1'b1, 132, 4, 8'h77);
    rd_chk("R5 any size counted", 1'b1, 12, 1, 1);
  endtask

  task automatic t_port;
    wr(1'b1, 0, 1, 1);
    rd_chk("R1 port idx", 1'b1, 0, 1, 4);
    rd_chk("R4 port off", 1'b1, 4, 1, 8'h84);
    rd_chk("R4 port off hi", 1'b1, 5, 1, 0);
    wr(1'b1, 132, 1, 8'h01);
    wr(1'b0, 132, 1, 8'h02);
    wr(1'b1, 2052, 1, 8'h03);
    rd_chk("R4 window-agnostic, span limited", 1'b1, 12, 1, 2);
  endtask

  task automatic t_name;
    string s;
    s = exp_name(4);
    for (int p = 0; p < s.len(); p++)
      rd_chk("R7 name byte", 1'b1, 16 + p, 1, int'(s[p]));
    rd_chk("R8 last in range", 1'b1, 21, 1, int'(s[5]));
    rd_chk("R8 size reaches end", 1'b1, 21, 2, 0);
    rd_chk("R8 terminator slot", 1'b1, 22, 1, 0);
    wr(1'b0, 0, 1, 0);
    rd_chk("R7 mem name", 1'b0, 16, 1, int'(exp_name(0)[0]));
    rd_chk("R8 mem last", 1'b0, 24, 1, int'(exp_name(0)[8]));
  endtask

  task automatic t_reject;
    wr(1'b0, 0, 1, 0);
    wr(1'b1, 0, 1, 3);
    rd_chk("R1 value 3 disarms", 1'b0, 0, 1, 0);
    rd_chk("R3 disarmed header zero", 1'b0, 1, 1, 0);
  endtask

  task automatic t_wrap;
    wr(1'b0, 0, 1, 1);
    for (int k = 0; k < 63; k++) wr(1'b0, 2049, 1, k);
    rd_chk("R11 count 63", 1'b0, 12, 1, 63);
    wr(1'b0, 2049, 1, 0);
    wr(1'b0, 2049, 1, 0);
    rd_chk("R11 wrapped", 1'b0, 12, 1, 1);
    rd_chk("R11 upper bytes zero", 1'b0, 13, 1, 0);
  endtask

  task automatic t_async_reset;
    wr(1'b0, 0, 1, 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R9 reset disarms", 1'b0, 1, 1, 0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_header_mem0();
    t_doorbell();
    t_match();
    t_port();
    t_name();
    t_reject();
    t_wrap();
    t_async_reset();
    done = 1'b1;
    finish_run();
  end
endmodule